// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block sequences a successive-approximation conversion for an external analog front end that holds the track-and-hold, the capacitive DAC and the comparator. A one-clock start strobe in idle starts a conversion. The controller raises the hold line and runs an MSB-first binary search, one bit decision per clock. The comparator result arriving on each clock decides the bit under trial.

When the last bit is decided, the hold line drops for a fixed sampling window. A one-cycle end-of-conversion pulse opens this window and a one-cycle DAC reset strobe follows it. The controller also issues that DAC reset strobe while reset is held and in the first cycle after reset is released. The finished code stays on the output until the next conversion starts. A new start strobe may arrive in the last cycle of the sampling window, so conversions can run back to back at one result every NBITS + SAMPLE_CYCLES clocks.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Reset is synchronous and active low. At a clock edge where rst_n is low, hold, eoc and code all go to 0.
- R2: dac_rst is 1 while reset is held and for exactly the first cycle after reset is released. A soc sampled in that first cycle is ignored, so hold stays 0.
- R3: soc sampled high at an edge while idle makes hold 1 from that edge, for exactly NBITS consecutive cycles.
- R4: code is 0 from reset until the first conversion. In the first hold cycle of every conversion, code holds only its MSB set (10'h200 with defaults).
- R5: In each hold cycle exactly one bit is under trial. At the edge ending the cycle, that bit keeps 1 if cmp is 1 and becomes 0 otherwise, and the next lower bit is set as the new trial. The final code equals the sequence of cmp values, MSB first.
- R6: After the hold phase, hold stays 0 for exactly SAMPLE_CYCLES cycles (3 with defaults) when soc is given in the last of those cycles. That cycle is the earliest one in which soc is accepted.
- R7: eoc is a one-cycle pulse in the first cycle after hold falls, and eoc is never 1 at the same time as hold.
- R8: dac_rst is a one-cycle pulse in the cycle directly after eoc.
- R9: From eoc until the next accepted soc, code stays at the final result, whatever cmp does.
- R10: A soc sampled during the hold phase or before the last sampling cycle is ignored. The running conversion keeps its timing and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soc | input | 1 | Start-of-conversion strobe, one clock wide |
| cmp | input | 1 | Comparator result for the bit under trial |
| hold | output | 1 | Track-and-hold control, high during the search |
| dac_rst | output | 1 | DAC reset strobe |
| eoc | output | 1 | End-of-conversion pulse |
| code | output | NBITS | Conversion result / trial code to the DAC |

## Verification
The bench builds the controller with its default parameters, NBITS = 10 and SAMPLE_CYCLES = 3, so one frame lasts thirteen clocks. These values expose every trial step of a full ten-bit search and the exact edge where a back-to-back start becomes legal. The comparator patterns cover all ones, all zeros, the two alternating patterns and a sparse pattern. Start strobes that land in the power-up cycle, in mid-search and in the first sampling cycles must leave both the timing and the result untouched.

// File: rtl/sarc_pkg.sv
// Shared types for the SAR conversion controller.
package sarc_pkg;

    // Controller phase: power-up DAC reset, idle, bit search, sampling window.
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_CONV  = 2'd2,
        ST_TRACK = 2'd3
    } sarc_state_t;

endpackage

// File: rtl/sarc_sequencer.sv
// Phase sequencer for the SAR conversion controller.
// Does: decides when a conversion starts, counts NBITS search cycles with
// hold high, then SAMPLE_CYCLES sampling cycles with eoc in the first and the
// DAC reset strobe in the second. Also issues the power-up DAC reset.
// Assumes: soc is synchronous to clk; SAMPLE_CYCLES >= 2 so that the DAC reset
// strobe fits inside the sampling window.
module sarc_sequencer
    import sarc_pkg::*;
#(
    parameter int NBITS         = 10,
    parameter int SAMPLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soc,
    output logic start_o,
    output logic step_o,
    output logic hold_o,
    output logic eoc_o,
    output logic dac_rst_o
);

    localparam int MAXC = (NBITS > SAMPLE_CYCLES) ? NBITS : SAMPLE_CYCLES;
    localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] CONV_LAST  = CW'(NBITS - 1);
    localparam logic [CW-1:0] TRACK_LAST = CW'(SAMPLE_CYCLES - 1);
    localparam logic [CW-1:0] RST_SLOT   = CW'(1);

    sarc_state_t   state;
    logic [CW-1:0] cnt;
    logic          last_track;

    // Last sampling cycle: the earliest point a new start is accepted.
    assign last_track = (state == ST_TRACK) && (cnt == TRACK_LAST);

    // Start is accepted only when idle or in the final sampling cycle.
    assign start_o = soc && ((state == ST_IDLE) || last_track);

    // Output decode from the registered phase and counter.
    always_comb begin
        step_o    = (state == ST_CONV);
        hold_o    = (state == ST_CONV);
        eoc_o     = (state == ST_TRACK) && (cnt == '0);
        dac_rst_o = (state == ST_INIT) || ((state == ST_TRACK) && (cnt == RST_SLOT));
    end

    // Phase register and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT;
            cnt   <= '0;
        end else begin
            case (state)
                ST_INIT: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
                ST_IDLE: begin
                    if (start_o) begin
                        state <= ST_CONV;
                    end
                    cnt <= '0;
                end
                ST_CONV: begin
                    if (cnt == CONV_LAST) begin
                        state <= ST_TRACK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (last_track) begin
                        state <= start_o ? ST_CONV : ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_SOC_IGNORED_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && cnt != CONV_LAST) |=> (state == ST_CONV)); // R10
    AST_SOC_IGNORED_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && !last_track) |=> (state == ST_TRACK)); // R10
    AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/sarc_search_reg.sv
// Successive-approximation register.
// Does: on start loads the MSB as the first trial; on every step keeps or
// clears the bit under trial according to cmp and sets the next lower bit.
// Holds its value whenever neither start nor step is active.
// Assumes: start and step are never high in the same cycle; step is given for
// exactly NBITS cycles after each start.
module sarc_search_reg #(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] code_o
);

    localparam int MSB = NBITS - 1;
    localparam logic [NBITS-1:0] MSB_ONLY = NBITS'(1) << MSB;

    logic [NBITS-1:0] ptr;
    logic [NBITS-1:0] ptr_dn;
    logic [NBITS-1:0] code_nxt;

    // Position of the next trial bit, one below the current one.
    assign ptr_dn = ptr >> 1;

    // Per-bit next value: load, decide, set next trial, or hold.
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        assign code_nxt[b] = start_i ? 1'(b == MSB)
                           : !step_i ? code_o[b]
                           : ptr[b]   ? cmp_i
                           : ptr_dn[b] ? 1'b1
                           : code_o[b];
    end

    // Code and trial-pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            ptr    <= '0;
        end else begin
            code_o <= code_nxt;
            if (start_i) begin
                ptr <= MSB_ONLY;
            end else if (step_i) begin
                ptr <= ptr_dn;
            end
        end
    end

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr)); // R5
    AST_DECIDE_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i && ptr[0]) |=> (code_o[0] == $past(cmp_i))); // R5

endmodule

// File: rtl/sar_conv_ctrl.sv
// SAR ADC conversion controller, top level.
// Does: joins the phase sequencer and the approximation register, and drives
// hold, eoc, the DAC reset strobe and the code to the analog front end.
// Assumes: cmp is valid and synchronous to clk for the bit under trial by the
// end of each hold cycle.
module sar_conv_ctrl #(
    parameter int NBITS         = 10,
    parameter int SAMPLE_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soc,
    input  logic             cmp,
    output logic             hold,
    output logic             dac_rst,
    output logic             eoc,
    output logic [NBITS-1:0] code
);

    localparam logic [NBITS-1:0] FIRST_TRIAL = NBITS'(1) << (NBITS - 1);

    logic start;
    logic step;

    // Phase sequencing and strobes.
    sarc_sequencer #(
        .NBITS        (NBITS),
        .SAMPLE_CYCLES(SAMPLE_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soc      (soc),
        .start_o  (start),
        .step_o   (step),
        .hold_o   (hold),
        .eoc_o    (eoc),
        .dac_rst_o(dac_rst)
    );

    // Binary search register.
    sarc_search_reg #(
        .NBITS(NBITS)
    ) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .step_i (step),
        .cmp_i  (cmp),
        .code_o (code)
    );

    AST_EOC_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> ($past(hold) && !hold)); // R7
    AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc); // R7
    AST_DACRST_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> (dac_rst && !eoc)); // R8
    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (code == FIRST_TRIAL)); // R4
    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !start) |=> $stable(code)); // R9

endmodule

// File: tb/sar_conv_ctrl_tb.sv
// Directed bench for the SAR conversion controller.
module sar_conv_ctrl_tb;

    localparam int NBITS  = 10;
    localparam int SAMPLE = 3;
    localparam time TCLK  = 5ns;
    localparam logic [NBITS-1:0] FIRST = 10'h200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soc = 1'b0;
    logic             cmp = 1'b0;
    logic             hold;
    logic             dac_rst;
    logic             eoc;
    logic [NBITS-1:0] code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(TCLK / 2) clk = ~clk;

    sar_conv_ctrl #(.NBITS(NBITS), .SAMPLE_CYCLES(SAMPLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .soc(soc), .cmp(cmp),
        .hold(hold), .dac_rst(dac_rst), .eoc(eoc), .code(code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reset values, power-up DAC reset and soc ignored in that cycle (R1, R2).
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 hold", 32'(hold), 0);
        chk("R1 eoc", 32'(eoc), 0);
        chk("R1 code", 32'(code), 0);
        chk("R2 dac_rst in reset", 32'(dac_rst), 1);
        rst_n = 1'b1;
        soc   = 1'b1;
        chk("R2 dac_rst first cycle", 32'(dac_rst), 1);
        @(negedge clk);
        soc = 1'b0;
        chk("R2 dac_rst drops", 32'(dac_rst), 0);
        chk("R2 soc ignored", 32'(hold), 0);
        @(negedge clk);
        chk("R2 still idle", 32'(hold), 0);
        chk("R4 code zero before first conv", 32'(code), 0);
    endtask

    // Pulse soc from idle; returns just after the accepting edge.
    task automatic issue_soc();
        @(negedge clk);
        soc = 1'b1;
        @(negedge clk);
        soc = 1'b0;
    endtask

    // One conversion from just after the accepting edge. busy: extra soc
    // during search and early sampling (R10). chain: back-to-back start (R6).
    task automatic conv_body(input logic [NBITS-1:0] pat, input bit busy, input bit chain);
        logic [NBITS-1:0] exp = '0;
        chk("R3 hold rises", 32'(hold), 1);
        chk("R4 first trial", 32'(code), 32'(FIRST));
        for (int i = NBITS - 1; i >= 0; i--) begin
            chk("R3 hold high", 32'(hold), 1);
            chk("R5 trial code", 32'(code), 32'(exp | (NBITS'(1) << i)));
            cmp = pat[i];
            if (busy && i == 5) soc = 1'b1;
            @(negedge clk);
            soc = 1'b0;
            if (pat[i]) exp = exp | (NBITS'(1) << i);
        end
        cmp = ~cmp;
        chk("R6 hold low", 32'(hold), 0);
        chk("R7 eoc pulse", 32'(eoc), 1);
        chk("R5 final code", 32'(code), 32'(pat));
        if (busy) soc = 1'b1;
        @(negedge clk);
        soc = 1'b0;
        cmp = ~cmp;
        chk("R7 eoc one cycle", 32'(eoc), 0);
        chk("R8 dac_rst after eoc", 32'(dac_rst), 1);
        chk("R9 code held", 32'(code), 32'(pat));
        chk("R10 hold low after soc in track", 32'(hold), 0);
        @(negedge clk);
        chk("R8 dac_rst one cycle", 32'(dac_rst), 0);
        chk("R6 hold still low", 32'(hold), 0);
        chk("R9 code held 2", 32'(code), 32'(pat));
        if (chain) begin
            soc = 1'b1;
            @(negedge clk);
            soc = 1'b0;
            chk("R6 back-to-back start", 32'(hold), 1);
        end else begin
            @(negedge clk);
            chk("R6 idle after window", 32'(hold), 0);
            repeat (3) begin
                cmp = ~cmp;
                @(negedge clk);
                chk("R9 code stable in idle", 32'(code), 32'(pat));
                chk("R9 eoc low in idle", 32'(eoc), 0);
            end
        end
    endtask

    task automatic t_single(input logic [NBITS-1:0] pat);
        issue_soc();
        conv_body(pat, 1'b0, 1'b0);
    endtask

    task automatic t_busy(input logic [NBITS-1:0] pat);
        issue_soc();
        conv_body(pat, 1'b1, 1'b0);
    endtask

    task automatic t_chain();
        issue_soc();
        conv_body(10'h2AA, 1'b0, 1'b1);
        conv_body(10'h155, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_single(10'h3FF);
        t_single(10'h000);
        t_single(10'h201);
        t_busy(10'h2AA);
        t_chain();
        t_reset();
        t_single(10'h0F3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule